// File: doc/BRIEF.md
# Prioritized Address Window Chip-Select Decoder

This block sits between the core's address path and the external memory bus. Every access request carries an address, and the block decides which region that address belongs to. There are four programmable windows and one default region that catches any address no window claims. The block then drives a one-hot chip-select for that region and reports the region index. It also supplies the bus mode the region asks for: the data width (8 or 16 bits) and multiplexed or demultiplexed operation. Because the mode follows the active region, the bus changes its shape from one access to the next as accesses move between windows.

Each window is defined by a base address, a power-of-two size and an enable. An address belongs to the window when every bit at or above the size position equals the base. Windows may overlap, and a fixed ranking resolves the overlap: a higher-numbered window always wins over a lower-numbered one. Each region also holds a wait-state count and a ready polarity. An access lasts at least that many cycles beyond its first cycle, and it ends only when the ready input is sampled at the region's active level. A global line count limits how many low address bits are driven onto the bus.

Software programs all settings through a simple write port. The region, the kind of setting and the data are given in one cycle, and the write takes effect at the next rising clock edge. Everything the bus sees is latched when the access starts.

Top module: `addr_window_cs`

## Requirements
- R1: After synchronous reset, cs is all zero, win_idx is 0, busy and done are 0, bus16 and demux are 0, all windows are disabled, every region has zero wait states and active-low ready, and the line count is ADDR_W.
- R2: An address matched by no enabled window selects the default region: win_idx 0 and cs bit 0.
- R3: Window k (1..4) matches when it is enabled and the address bits at positions size and above equal the same bits of its base; a size of ADDR_W or more matches every address. On a match, win_idx is k and only cs bit k is set.
- R4: Where windows 4 and 3 both match, window 4 is selected.
- R5: Where windows 2 and 1 both match, window 2 is selected.
- R6: Where window 3 or 4 matches together with window 1 or 2, the upper window is selected.
- R7: bus16 and demux show the active region's settings; they are latched when the access starts and do not change while busy, even if that region is rewritten.
- R8: While busy, exactly one cs bit is set; while idle, cs is zero.
- R9: With a region wait count W and ready held at its active level, done pulses exactly W+1 cycles after the edge that accepts the request, and busy falls on that same edge.
- R10: Ready polarity is per region (mode bit 2: 1 = active high, 0 = active low); while ready is at its inactive level the access stays busy indefinitely, and it ends on the first edge that samples the active level.
- R11: ext_addr is the request address with only its low N bits kept, where N is the programmed line count; values above ADDR_W act as ADDR_W. The line count is written with kind 3 to region 0.
- R12: Base (kind 0) and size (kind 1) writes to region 0 are ignored, so the default region still catches unclaimed addresses.
- R13: A request that arrives while busy is ignored: win_idx and ext_addr hold their values, and no new access follows the current one.

Write encoding: cfg_kind 0 = base, 1 = size (low 5 data bits), 2 = mode, 3 = line count (low 6 data bits, region 0 only). Mode data bits are: bit 0 bus16, bit 1 demux, bit 2 ready polarity, bits 6:3 wait count, bit 7 window enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus reference clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an access (accepted only when idle) |
| addr | input | ADDR_W | Registered request address |
| ready_in | input | 1 | External ready, polarity per region |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 3 | Region to write (0 default, 1..4 windows) |
| cfg_kind | input | 2 | Setting selector |
| cfg_data | input | ADDR_W | Write data |
| cs | output | 5 | One-hot chip-selects, bit 0 default region |
| win_idx | output | 3 | Index of the active region |
| bus16 | output | 1 | 16-bit data width for this access |
| demux | output | 1 | Demultiplexed operation for this access |
| ext_addr | output | ADDR_W | Address limited to the active lines |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse after an access ends |

## Verification
The hardest case to reach is a conflict across the ranking, where an upper window sits inside a lower window that itself sits inside another lower window. The stimulus builds this by moving window 3 into the middle of window 2's range after the main table has run. Single addresses then hit three windows at once, or two windows at once just outside window 3's edge. Reaching a rewrite in the middle of an access, and a second request arriving while busy, also takes care. Both are set up by watching busy and then acting between clock edges while ready is held at its active level.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int WAIT_W = 4;

  // mode word layout: bit0 bus16, bit1 demux, bit2 ready polarity,
  // bits 6:3 wait count, bit7 window enable
  typedef struct packed {
    logic              en;
    logic [WAIT_W-1:0] waits;
    logic              rdy_hi;
    logic              demux;
    logic              bus16;
  } mode_t;

  localparam logic [1:0] K_BASE  = 2'd0;
  localparam logic [1:0] K_SIZE  = 2'd1;
  localparam logic [1:0] K_MODE  = 2'd2;
  localparam logic [1:0] K_LINES = 2'd3;
endpackage

// File: rtl/awd_cfg.sv
module awd_cfg
  import awd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NREG   = 5,
  parameter int REG_W  = 3,
  parameter int SIZE_W = 5,
  parameter int LINE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [REG_W-1:0]              region,
  input  logic [1:0]                    kind,
  input  logic [ADDR_W-1:0]             data,
  output logic [NREG-1:0][ADDR_W-1:0]   base_o,
  output logic [NREG-1:0][SIZE_W-1:0]   size_o,
  output mode_t [NREG-1:0]              mode_o,
  output logic [LINE_W-1:0]             lines_o
);
  localparam int MODE_W = $bits(mode_t);

  logic region_ok;
  assign region_ok = (int'(region) < NREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        base_o[i] <= '0;
        size_o[i] <= '0;
        mode_o[i] <= '0;
      end
      lines_o <= LINE_W'(ADDR_W);
    end else if (we && region_ok) begin
      case (kind)
        K_BASE:  if (region != '0) base_o[region] <= data;
        K_SIZE:  if (region != '0) size_o[region] <= data[SIZE_W-1:0];
        K_MODE:  mode_o[region] <= mode_t'(data[MODE_W-1:0]);
        default: if (region == '0) lines_o <= data[LINE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              en,
  output logic              hit
);
  logic [ADDR_W-1:0] care;

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) care[b] = (b >= int'(size));
    hit = en && (((addr ^ base) & care) == '0);
  end
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NWIN  = 4,
  parameter int REG_W = 3
) (
  input  logic [NWIN:1]    hit,
  output logic [REG_W-1:0] sel
);
  // higher window number always outranks a lower one
  always_comb begin
    sel = '0;
    for (int i = 1; i <= NWIN; i++)
      if (hit[i]) sel = REG_W'(i);
  end
endmodule

// File: rtl/awd_access.sv
module awd_access
  import awd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] waits,
  input  logic              rdy_hi,
  input  logic              ready_in,
  output logic              busy,
  output logic              done,
  output logic              end_now
);
  logic [WAIT_W-1:0] cnt;
  logic              pol_q;
  logic [WAIT_W-1:0] wq;
  logic [WAIT_W:0]   elapsed;

  assign end_now = busy && (cnt == '0) && (ready_in == pol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      pol_q   <= 1'b0;
      wq      <= '0;
      elapsed <= '0;
    end else begin
      done <= end_now;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= waits;
        wq      <= waits;
        pol_q   <= rdy_hi;
        elapsed <= '0;
      end else if (busy) begin
        if (!(&elapsed)) elapsed <= elapsed + 1'b1;
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (end_now) busy <= 1'b0;
      end
    end
  end

  // R9: an access never ends before its wait count has elapsed
  a_r9_min_wait: assert property (@(posedge clk) disable iff (rst)
    end_now |-> (elapsed >= {1'b0, wq}));
  // R10: completion requires ready at the latched active level
  a_r10_done_level: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ready_in) == $past(pol_q)));
  // R9: busy drops together with the done pulse
  a_r9_done_drops_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs
  import awd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NWIN   = 4,
  parameter int SIZE_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          ready_in,
  input  logic                          cfg_we,
  input  logic [$clog2(NWIN+1)-1:0]     cfg_region,
  input  logic [1:0]                    cfg_kind,
  input  logic [ADDR_W-1:0]             cfg_data,
  output logic [NWIN:0]                 cs,
  output logic [$clog2(NWIN+1)-1:0]     win_idx,
  output logic                          bus16,
  output logic                          demux,
  output logic [ADDR_W-1:0]             ext_addr,
  output logic                          busy,
  output logic                          done
);
  localparam int NREG   = NWIN + 1;
  localparam int REG_W  = $clog2(NREG);
  localparam int LINE_W = $clog2(ADDR_W + 1) + 1;

  logic [NREG-1:0][ADDR_W-1:0] base_w;
  logic [NREG-1:0][SIZE_W-1:0] size_w;
  mode_t [NREG-1:0]            mode_w;
  logic [LINE_W-1:0]           lines;
  logic [NWIN:1]               hit;
  logic [REG_W-1:0]            sel;
  mode_t                       act;
  logic [ADDR_W-1:0]           lmask;
  logic                        start;
  logic                        end_now;

  awd_cfg #(.ADDR_W(ADDR_W), .NREG(NREG), .REG_W(REG_W),
            .SIZE_W(SIZE_W), .LINE_W(LINE_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .region(cfg_region),
    .kind(cfg_kind), .data(cfg_data),
    .base_o(base_w), .size_o(size_w), .mode_o(mode_w), .lines_o(lines)
  );

  for (genvar k = 1; k <= NWIN; k++) begin : g_win
    awd_win_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_match (
      .addr(addr), .base(base_w[k]), .size(size_w[k]),
      .en(mode_w[k].en), .hit(hit[k])
    );
  end

  awd_prio #(.NWIN(NWIN), .REG_W(REG_W)) u_prio (.hit(hit), .sel(sel));

  assign act   = mode_w[sel];
  assign start = req && !busy;

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) lmask[b] = (b < int'(lines));
  end

  awd_access u_acc (
    .clk(clk), .rst(rst), .start(start), .waits(act.waits),
    .rdy_hi(act.rdy_hi), .ready_in(ready_in),
    .busy(busy), .done(done), .end_now(end_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs       <= '0;
      win_idx  <= '0;
      bus16    <= 1'b0;
      demux    <= 1'b0;
      ext_addr <= '0;
    end else if (start) begin
      cs       <= NREG'(1) << sel;
      win_idx  <= sel;
      bus16    <= act.bus16;
      demux    <= act.demux;
      ext_addr <= addr & lmask;
    end else if (end_now) begin
      cs <= '0;
    end
  end

  // R8: exactly one select during an access
  a_r8_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(cs) == 1));
  // R8: no select while idle
  a_r8_idle_no_cs: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs == '0));
  // R3: asserted select agrees with the reported index
  a_r3_cs_matches_idx: assert property (@(posedge clk) disable iff (rst)
    busy |-> cs[win_idx]);
  // R7: mode held for the whole access
  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(bus16) && $stable(demux)));
  // R13: a second request never disturbs the running access
  a_r13_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(win_idx) && $stable(ext_addr)));
endmodule

// File: tb/tb_addr_window_cs.sv
module tb_addr_window_cs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ready_in = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_region = '0;
  logic [1:0]    cfg_kind = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [4:0]    cs;
  logic [2:0]    win_idx;
  logic          bus16, demux, busy, done;
  logic [AW-1:0] ext_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected per-region settings kept by the bench
  int exp_w[5];
  bit exp_pol[5];
  bit exp_dm[5];
  bit exp_b16[5];
  int exp_lines = AW;

  // {address, expected region}
  localparam logic [26:0] VEC [0:12] = '{
    {24'h000010, 3'd0}, {24'h100000, 3'd1}, {24'h1FFFFF, 3'd1},
    {24'h180000, 3'd2}, {24'h18FFFF, 3'd2}, {24'h190000, 3'd1},
    {24'h400000, 3'd3}, {24'h43FFFF, 3'd3}, {24'h440000, 3'd4},
    {24'h44FFFF, 3'd4}, {24'h450000, 3'd3}, {24'h500000, 3'd0},
    {24'hFFFFFF, 3'd0}
  };

  addr_window_cs dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .ready_in(ready_in),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_kind(cfg_kind),
    .cfg_data(cfg_data), .cs(cs), .win_idx(win_idx), .bus16(bus16),
    .demux(demux), .ext_addr(ext_addr), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int r, input int k, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = 3'(r); cfg_kind = 2'(k); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] mk(input bit en, input int w, input bit pol,
                                        input bit dm, input bit b16);
    return AW'({en, 4'(w), pol, dm, b16});
  endfunction

  task automatic set_mode(input int r, input bit en, input int w, input bit pol,
                          input bit dm, input bit b16);
    exp_w[r] = w; exp_pol[r] = pol; exp_dm[r] = dm; exp_b16[r] = b16;
    wr(r, 2, mk(en, w, pol, dm, b16));
  endtask

  function automatic logic [AW-1:0] lm(input logic [AW-1:0] a);
    int n = (exp_lines > AW) ? AW : exp_lines;
    for (int b = 0; b < AW; b++) if (b >= n) a[b] = 1'b0;
    return a;
  endfunction

  // one access with ready held active; checks select, mode and length
  task automatic run_acc(input logic [AW-1:0] a, input int r, input string tag);
    int n = 0;
    @(negedge clk);
    ready_in = exp_pol[r]; req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " cs"}, 32'(cs), 32'(5'd1 << r));
    chk({tag, " idx"}, 32'(win_idx), 32'(r));
    chk({"R7 bus16 ", tag}, 32'(bus16), 32'(exp_b16[r]));
    chk({"R7 demux ", tag}, 32'(demux), 32'(exp_dm[r]));
    chk({"R11 ext_addr ", tag}, 32'(ext_addr), 32'(lm(a)));
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({"R9 length ", tag}, 32'(n), 32'(exp_w[r] + 1));
    chk({"R9 busy low at done ", tag}, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      exp_w[i] = 0; exp_pol[i] = 0; exp_dm[i] = 0; exp_b16[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cs", 32'(cs), 0);
    chk("R1 idx", 32'(win_idx), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 bus16", 32'(bus16), 0);
    chk("R1 demux", 32'(demux), 0);
    // R1/R2: unconfigured windows, everything lands in default
    run_acc(24'h440000, 0, "R1 R2 unconfigured");

    // configuration
    set_mode(0, 0, 2, 1, 1, 1);
    wr(1, 0, 24'h100000); wr(1, 1, 24'd20); set_mode(1, 1, 1, 1, 0, 1);
    wr(2, 0, 24'h180000); wr(2, 1, 24'd16); set_mode(2, 1, 2, 0, 1, 0);
    wr(3, 0, 24'h400000); wr(3, 1, 24'd20); set_mode(3, 1, 0, 1, 1, 1);
    wr(4, 0, 24'h440000); wr(4, 1, 24'd16); set_mode(4, 1, 3, 0, 0, 1);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 13; v++)
      run_acc(VEC[v][26:3], int'(VEC[v][2:0]), "R2 R3 R4 R5 table");

    // R6: window 3 moved inside window 2 (and window 1)
    wr(3, 0, 24'h180000); wr(3, 1, 24'd12);
    run_acc(24'h180800, 3, "R6 upper over lower");
    run_acc(24'h181000, 2, "R6 just outside w3");

    // R10: active-low ready held inactive on window 2
    @(negedge clk);
    ready_in = 1'b1; req = 1'b1; addr = 24'h18F000;
    @(negedge clk);
    req = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 stalled busy", 32'(busy), 1);
    chk("R10 stalled done", 32'(done), 0);
    ready_in = 1'b0;
    @(negedge clk);
    chk("R10 ends on active level", 32'(done), 1);

    // R7: rewrite window 4 mode during its access
    @(negedge clk);
    ready_in = 1'b0; req = 1'b1; addr = 24'h440000;
    @(negedge clk);
    req = 1'b0;
    cfg_we = 1'b1; cfg_region = 3'd4; cfg_kind = 2'd2;
    cfg_data = mk(1, 3, 0, 1, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R7 bus16 latched", 32'(bus16), 1);
    chk("R7 demux latched", 32'(demux), 0);
    while (!done) @(negedge clk);
    exp_dm[4] = 1; exp_b16[4] = 0;
    run_acc(24'h440000, 4, "R7 new mode");

    // R13: request during a busy access
    @(negedge clk);
    ready_in = 1'b0; req = 1'b1; addr = 24'h44ABCD;
    @(negedge clk);
    addr = 24'h000010;
    @(negedge clk);
    req = 1'b0;
    chk("R13 idx held", 32'(win_idx), 4);
    chk("R13 ext_addr held", 32'(ext_addr), 32'h44ABCD);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R13 no restart busy", 32'(busy), 0);
    chk("R13 no restart cs", 32'(cs), 0);

    // R11: address line limiting
    wr(0, 3, 24'd16); exp_lines = 16;
    run_acc(24'h44ABCD, 4, "R11 16 lines");
    wr(0, 3, 24'd30); exp_lines = 30;
    run_acc(24'h44ABCD, 4, "R11 clamp");
    wr(0, 3, 24'd0); exp_lines = 0;
    run_acc(24'h44ABCD, 4, "R11 zero lines");
    wr(0, 3, 24'd24); exp_lines = 24;

    // R12: base/size writes to the default region are ignored
    wr(0, 0, 24'h500000); wr(0, 1, 24'd4);
    run_acc(24'h500000, 0, "R12 default base");
    run_acc(24'h600000, 0, "R12 default other");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule